// File: doc/BRIEF.md
# Flow-Order Restoring Output Buffer

This block sits at one output of a two-stage load-balanced switch and puts cells back into arrival order without carrying sequence numbers. Every arriving cell carries a source-input index, the index of the middle-stage port it crossed, and an opaque tag. The first stage spreads each input's cells over the middle ports in strict rotation. So the next in-order cell of a given input is always known to sit behind one particular middle port.

The buffer keeps one small FIFO for every (source, middle port) pair. It also keeps one expected-port pointer per source. A ring of source indices lists the sources whose expected cell is present. In every clock slot the source at the front of that ring sends exactly one cell and then moves its pointer on by one port. The source goes back to the end of the ring if its following cell is already there; otherwise it leaves the ring. If a cell arrives while its FIFO is full, the cell is discarded and a one-cycle overflow pulse is raised.

Top module: `rsq_buffer`

## Requirements
- R1: After reset no departure is signalled, the overflow pulse is low, the ring is empty, and every source expects its first cell behind middle port 0.
- R2: Cells of one source that cross the same middle port leave in the order they arrived, and the departing tag equals the arriving tag.
- R3: A source releases only the cell behind its expected port. Cells that reach other ports of the same source wait, and no departure is signalled for them.
- R4: After a source sends a cell from port j, its expected port becomes (j + 1) mod N, so port N-1 is followed by port 0.
- R5: A source index is held in the ring at most once. It is appended when that source's expected cell becomes present.
- R6: At most one cell departs per slot, and it comes from the source at the ring's front. A cell arriving at the front of an empty ring with its expected cell is presented on the departure outputs exactly two clock edges after its arrival edge.
- R7: After sending, a source goes back to the tail of the ring if its next expected cell is present, and leaves the ring otherwise. Ready sources are therefore served in turn.
- R8: If the cell that a departing source will expect next arrives in the same slot as the departure, the source goes back to the ring without missing a slot.
- R9: An arrival to a FIFO that is full at the start of the slot is discarded. The overflow output is high for exactly the following cycle.
- R10: When one slot both returns the departing source and makes a different source ready, the departing source is placed ahead of the newly ready one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | An arriving cell is present this slot |
| arr_src | input | 2 | Source input of the arriving cell |
| arr_mid | input | 2 | Middle-stage port the arriving cell crossed |
| arr_tag | input | 8 | Payload tag of the arriving cell |
| dep_valid | output | 1 | A cell departs (registered) |
| dep_src | output | 2 | Source input of the departing cell |
| dep_tag | output | 8 | Payload tag of the departing cell |
| ovf | output | 1 | Pulse: the previous slot's arrival was discarded |

## Verification
An arrival is written into its FIFO and the ring at the edge where it is sampled. Its departure shows up one edge later than the slot in which its source reaches the ring's front, which makes two edges from arrival to output for an empty ring. The overflow pulse follows the rejected arrival by one edge. The bench drives inputs on falling edges and reads the outputs on the following falling edges. Ordering is checked against a scoreboard of expected (source, tag) pairs, while the latency and same-slot cases are checked by counting the falling edges between stimulus and departure.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int unsigned RSQ_PORTS_DEF = 4;
    localparam int unsigned RSQ_DEPTH_DEF = 4;
    localparam int unsigned RSQ_TAG_W_DEF = 8;

    function automatic int unsigned rsq_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rsq_fifo.sv
module rsq_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [TAG_W-1:0] din,
    output logic [TAG_W-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = rsq_pkg::rsq_idx_w(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [TAG_W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= din;
    end

    // R9: the control must never write into a full queue
    p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3: only a present cell may be released
    p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rsq_depq.sv
module rsq_depq #(
    parameter int unsigned N = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pop,
    input  logic                              push_a,
    input  logic [rsq_pkg::rsq_idx_w(N)-1:0]  idx_a,
    input  logic                              push_b,
    input  logic [rsq_pkg::rsq_idx_w(N)-1:0]  idx_b,
    output logic [rsq_pkg::rsq_idx_w(N)-1:0]  head,
    output logic                              nonempty,
    output logic [$clog2(N+1)-1:0]            count
);
    localparam int unsigned IW = rsq_pkg::rsq_idx_w(N);
    localparam int unsigned CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0][IW-1:0] slot;
        logic [IW-1:0]        hd;
        logic [IW-1:0]        tl;
        logic [CW-1:0]        cnt;
    } ring_st_t;

    ring_st_t st_d, st_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(N - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head     = st_q.slot[st_q.hd];
    assign nonempty = (st_q.cnt != '0);
    assign count    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.hd  = step(st_q.hd);
            st_d.cnt = st_d.cnt - 1'b1;
        end
        if (push_a) begin
            st_d.slot[st_d.tl] = idx_a;
            st_d.tl  = step(st_d.tl);
            st_d.cnt = st_d.cnt + 1'b1;
        end
        if (push_b) begin
            st_d.slot[st_d.tl] = idx_b;
            st_d.tl  = step(st_d.tl);
            st_d.cnt = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the ring never holds more than one entry per source
    p_ring_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(N));
    // R10: two appends in one slot always name different sources
    p_two_push_distinct_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_a && push_b) |-> (idx_a != idx_b));
    // R6: a pop needs a non-empty ring
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/rsq_buffer.sv
module rsq_buffer #(
    parameter int unsigned N     = rsq_pkg::RSQ_PORTS_DEF,
    parameter int unsigned DEPTH = rsq_pkg::RSQ_DEPTH_DEF,
    parameter int unsigned TAG_W = rsq_pkg::RSQ_TAG_W_DEF
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             arr_valid,
    input  logic [rsq_pkg::rsq_idx_w(N)-1:0] arr_src,
    input  logic [rsq_pkg::rsq_idx_w(N)-1:0] arr_mid,
    input  logic [TAG_W-1:0]                 arr_tag,
    output logic                             dep_valid,
    output logic [rsq_pkg::rsq_idx_w(N)-1:0] dep_src,
    output logic [TAG_W-1:0]                 dep_tag,
    output logic                             ovf
);
    localparam int unsigned IW = rsq_pkg::rsq_idx_w(N);
    localparam int unsigned CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0][IW-1:0] ptr;
        logic [N-1:0]         inq;
        logic                 dv;
        logic [IW-1:0]        ds;
        logic [TAG_W-1:0]     dt;
        logic                 ovf;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [N-1:0][N-1:0] f_push, f_pop, f_empty, f_full;
    logic [TAG_W-1:0]    f_dout [N][N];

    logic          dq_nonempty, dq_pop, dq_push_a, dq_push_b;
    logic [IW-1:0] dq_head;
    logic [CW-1:0] dq_count;

    logic          arr_ok;
    logic [IW-1:0] hp, hnx;

    for (genvar gi = 0; gi < N; gi++) begin : g_src
        for (genvar gj = 0; gj < N; gj++) begin : g_mid
            rsq_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (f_push[gi][gj]),
                .pop   (f_pop[gi][gj]),
                .din   (arr_tag),
                .dout  (f_dout[gi][gj]),
                .empty (f_empty[gi][gj]),
                .full  (f_full[gi][gj])
            );
        end
    end

    rsq_depq #(.N(N)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (dq_pop),
        .push_a   (dq_push_a),
        .idx_a    (dq_head),
        .push_b   (dq_push_b),
        .idx_b    (arr_src),
        .head     (dq_head),
        .nonempty (dq_nonempty),
        .count    (dq_count)
    );

    always_comb begin
        st_d      = st_q;
        f_push    = '0;
        f_pop     = '0;
        dq_push_a = 1'b0;
        dq_push_b = 1'b0;
        dq_pop    = dq_nonempty;

        arr_ok = arr_valid && !f_full[arr_src][arr_mid];
        hp     = st_q.ptr[dq_head];
        hnx    = (hp == IW'(N - 1)) ? '0 : hp + 1'b1;

        if (arr_ok) f_push[arr_src][arr_mid] = 1'b1;
        st_d.ovf = arr_valid && f_full[arr_src][arr_mid];

        st_d.dv = dq_nonempty;
        st_d.ds = dq_head;
        st_d.dt = f_dout[dq_head][hp];

        if (dq_nonempty) begin
            f_pop[dq_head][hp]   = 1'b1;
            st_d.ptr[dq_head]    = hnx;
            st_d.inq[dq_head]    = 1'b0;
            if (!f_empty[dq_head][hnx] ||
                (arr_ok && arr_src == dq_head && arr_mid == hnx)) begin
                dq_push_a         = 1'b1;
                st_d.inq[dq_head] = 1'b1;
            end
        end

        if (arr_ok && !(dq_nonempty && arr_src == dq_head) &&
            !st_q.inq[arr_src] && arr_mid == st_q.ptr[arr_src]) begin
            dq_push_b          = 1'b1;
            st_d.inq[arr_src]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dep_valid = st_q.dv;
    assign dep_src   = st_q.ds;
    assign dep_tag   = st_q.dt;
    assign ovf       = st_q.ovf;

    // R5: ring occupancy matches the membership flags, so no index is duplicated
    p_no_dup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dq_count) == $countones(st_q.inq));
    // R6: a departing source was a ring member in the slot it was served
    p_dep_from_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> $past(st_q.inq[dq_head]));
    // R4: serving a source moves its expected port
    p_ptr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> (st_q.ptr[dep_src] != $past(st_q.ptr[dq_head])));
    // R9: an overflow pulse needs an arrival in the slot before
    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(arr_valid));
endmodule

// File: tb/sim_rsq_buffer.sv
module sim_rsq_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arr_valid = 1'b0;
    logic [1:0] arr_src = '0;
    logic [1:0] arr_mid = '0;
    logic [7:0] arr_tag = '0;
    logic       dep_valid;
    logic [1:0] dep_src;
    logic [7:0] dep_tag;
    logic       ovf;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cyc_52 = -1;
    int cyc_53 = -1;
    bit done   = 1'b0;

    typedef struct packed { logic [1:0] s; logic [7:0] t; } exp_t;
    exp_t sb [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rsq_buffer u0 (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_src(arr_src),
        .arr_mid(arr_mid), .arr_tag(arr_tag), .dep_valid(dep_valid),
        .dep_src(dep_src), .dep_tag(dep_tag), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_dep(input logic [1:0] s, input logic [7:0] t);
        sb.push_back({s, t});
    endtask

    task automatic send(input logic [1:0] s, input logic [1:0] m, input logic [7:0] t);
        @(negedge clk);
        arr_valid = 1'b1; arr_src = s; arr_mid = m; arr_tag = t;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            arr_valid = 1'b0;
        end
    endtask

    // scoreboard monitor: R2 ordering and R7 service order
    always @(negedge clk) begin
        if (rst_n && dep_valid) begin
            if (dep_tag == 8'h52) cyc_52 = cyc;
            if (dep_tag == 8'h53) cyc_53 = cyc;
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected departure", int'(dep_tag), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(dep_src == e.s && dep_tag == e.t, "R2/R7 departure order",
                      int'({dep_src, dep_tag}), int'({e.s, e.t}));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dep_valid == 1'b0, "R1 reset dep_valid", int'(dep_valid), 0);
        check(ovf == 1'b0, "R1 reset ovf", int'(ovf), 0);

        // R1/R6: source 0 expects port 0; two-edge latency into an empty ring
        expect_dep(2'd0, 8'h10);
        send(2'd0, 2'd0, 8'h10);
        @(negedge clk); arr_valid = 1'b0;
        check(dep_valid == 1'b0, "R6 not yet due", int'(dep_valid), 0);
        @(negedge clk);
        check(dep_valid == 1'b1 && dep_tag == 8'h10, "R6 due two edges after arrival",
              int'({dep_valid, dep_tag}), int'({1'b1, 8'h10}));
        expect_dep(2'd0, 8'h11);
        send(2'd0, 2'd1, 8'h11);
        idle(5);

        // R3: source 1 cells at ports 2,1,3 wait for port 0
        expect_dep(2'd1, 8'h20); expect_dep(2'd1, 8'h21);
        expect_dep(2'd1, 8'h22); expect_dep(2'd1, 8'h23);
        send(2'd1, 2'd2, 8'h22);
        send(2'd1, 2'd1, 8'h21);
        send(2'd1, 2'd3, 8'h23);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); arr_valid = 1'b0;
            check(dep_valid == 1'b0, "R3 held while expected cell missing", int'(dep_valid), 0);
        end
        send(2'd1, 2'd0, 8'h20);
        idle(8);

        // R4: source 1 pointer wrapped to port 0
        expect_dep(2'd1, 8'h24);
        send(2'd1, 2'd0, 8'h24);
        idle(5);

        // R7/R10: interleaved service of sources 2 and 3
        expect_dep(2'd2, 8'h30); expect_dep(2'd2, 8'h31); expect_dep(2'd3, 8'h40);
        expect_dep(2'd2, 8'h32); expect_dep(2'd3, 8'h41); expect_dep(2'd3, 8'h42);
        send(2'd2, 2'd1, 8'h31);
        send(2'd2, 2'd2, 8'h32);
        send(2'd3, 2'd1, 8'h41);
        send(2'd3, 2'd2, 8'h42);
        send(2'd2, 2'd0, 8'h30);
        send(2'd3, 2'd0, 8'h40);
        idle(12);

        // R8: next expected cell arrives in the departure slot
        expect_dep(2'd0, 8'h52); expect_dep(2'd0, 8'h53);
        send(2'd0, 2'd2, 8'h52);
        send(2'd0, 2'd3, 8'h53);
        idle(6);
        check(cyc_52 >= 0 && cyc_53 == cyc_52 + 1, "R8 back-to-back departure",
              cyc_53 - cyc_52, 1);

        // R9: fill source 2 port 0 (source 2 now expects port 3)
        for (int k = 0; k < 4; k++) begin
            send(2'd2, 2'd0, 8'h60 + 8'(k));
        end
        @(negedge clk);
        check(ovf == 1'b0, "R9 no overflow below capacity", int'(ovf), 0);
        arr_valid = 1'b1; arr_src = 2'd2; arr_mid = 2'd0; arr_tag = 8'h64;
        @(negedge clk); arr_valid = 1'b0;
        check(ovf == 1'b1, "R9 overflow pulse", int'(ovf), 1);
        @(negedge clk);
        check(ovf == 1'b0, "R9 pulse lasts one cycle", int'(ovf), 0);
        check(dep_valid == 1'b0, "R9 full queue not released early", int'(dep_valid), 0);

        // R2: drain in FIFO order; the dropped 0x64 never appears
        expect_dep(2'd2, 8'h70); expect_dep(2'd2, 8'h60);
        send(2'd2, 2'd3, 8'h70);
        idle(6);
        for (int r = 0; r < 3; r++) begin
            expect_dep(2'd2, 8'h80 + 8'(r));
            expect_dep(2'd2, 8'h90 + 8'(r));
            expect_dep(2'd2, 8'hA0 + 8'(r));
            expect_dep(2'd2, 8'h61 + 8'(r));
            send(2'd2, 2'd1, 8'h80 + 8'(r));
            send(2'd2, 2'd2, 8'h90 + 8'(r));
            send(2'd2, 2'd3, 8'hA0 + 8'(r));
            idle(8);
        end

        idle(10);
        check(sb.size() == 0, "R2 all expected cells departed", sb.size(), 0);
        check(dep_valid == 1'b0, "R9 dropped cell absent", int'(dep_valid), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule